// File: doc/BRIEF.md
# Midscale Step Period Calibrator

This block sets the shift-clock divide count of a relaxation DAC sequencer so that the analog step across the midpoint of the code range comes out right. On request it runs a loop. Each pass asks the sequencer for two conversions: first the code with only the top bit set, then the code one below it. An external window comparator measures the difference between the two held voltages. When the second conversion reports done, the block samples the comparator and reads its verdict. If the difference is inside the window, the current count is kept. If the step is too large, the count is lowered. If the step is too small, the count is raised. A new pair of conversions then follows.

The correction step starts at a parameterized size. It is halved, never below one, each time the direction of correction flips. The count is held between a parameterized floor and ceiling. Running into either limit ends the run with an error. An iteration cap also ends the run with an error if the window is never reached. The comparator itself is outside the block.

Top module: `relax_period_cal`

## Requirements
- R1: Each pass issues two conversion requests in a fixed order: first `seq_code` = 2^(N-1) (only the top bit set), then, after `seq_done`, `seq_code` = 2^(N-1)-1.
- R2: The comparator inputs are sampled only in the cycle where `seq_done` ends the second conversion of a pass. Their values at any other time, including when the first conversion completes, have no effect.
- R3: When the sampled in-window input is 1, which takes priority over the other two, `cal_ok` rises, `period_cnt` is kept and no further conversion is requested.
- R4: Otherwise a sampled too-high input (step too large) lowers `period_cnt` by the current step, and a sampled too-low input raises it by the current step.
- R5: The step starts at STEP_INIT. When the correction direction is opposite to the previous pass's direction, the step is halved before it is applied, with a floor of 1.
- R6: After every adjustment that stays within limits, a new pair of conversions starts with the midscale code.
- R7: If an adjustment would take the count below P_MIN or above P_MAX, `period_cnt` is set to that limit, `cal_err` rises and the run stops. `period_cnt` always stays within [P_MIN, P_MAX].
- R8: If MAX_ITER passes end without the window being reached, `cal_err` rises after the last pass and the count is left unchanged by that pass.
- R9: After reset `period_cnt` = P_INIT, and `cal_ok`, `cal_err` and `seq_start` are 0.
- R10: A `cal_start` pulse while idle clears both flags and reloads P_INIT and STEP_INIT. A `cal_start` pulse during a run has no effect.
- R11: `seq_start` is a single-cycle pulse, and only one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Pulse to begin a calibration run |
| seq_code | output | N | Code to be converted by the sequencer |
| seq_start | output | 1 | One-cycle conversion request |
| seq_done | input | 1 | Sequencer pulse: conversion finished, voltage held |
| cmp_high | input | 1 | Midscale step larger than the window |
| cmp_low | input | 1 | Midscale step smaller than the window |
| cmp_in_win | input | 1 | Midscale step inside the window |
| period_cnt | output | PW | Shift-period divide count for the sequencer |
| cal_ok | output | 1 | Run ended with the step inside the window |
| cal_err | output | 1 | Run ended at a limit or at the iteration cap |

## Verification
The bench builds the block with N=6, PW=6, P_MIN=4, P_MAX=40, P_INIT=20, STEP_INIT=8 and MAX_ITER=12. With these values, both clamps can be reached within two or three passes. The iteration cap can be reached by a comparator model whose ideal count lies halfway between two integers. The step then shrinks to one and keeps flipping direction, so the window is never reached. With a short run per calibration, many random targets and tolerances fit in the bench. The count at the start of each pass is compared with a trace that the bench computes itself.

// File: rtl/mscal_pkg.sv
package mscal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ_HI  = 3'd1,
    ST_WAIT_HI = 3'd2,
    ST_REQ_LO  = 3'd3,
    ST_WAIT_LO = 3'd4,
    ST_EVAL    = 3'd5
  } cal_state_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

  typedef struct packed {
    logic hi;
    logic lo;
    logic win;
  } cmp_t;

  // step after an optional reversal: half, never below one
  function automatic int next_step(int step, logic reversed);
    int h;
    h = step / 2;
    if (!reversed) return step;
    return (h < 1) ? 1 : h;
  endfunction

  // candidate count before clamping
  function automatic int moved(int period, int step, dir_e d);
    if (d == DIR_DOWN) return period - step;
    if (d == DIR_UP) return period + step;
    return period;
  endfunction

  // correction direction from a sampled verdict (window wins, then high)
  function automatic dir_e decide(cmp_t c);
    if (c.win) return DIR_NONE;
    if (c.hi) return DIR_DOWN;
    if (c.lo) return DIR_UP;
    return DIR_NONE;
  endfunction

endpackage

// File: rtl/mscal_adjust.sv
module mscal_adjust
  import mscal_pkg::*;
#(
  parameter int PW    = 10,
  parameter int P_MIN = 8,
  parameter int P_MAX = 1000
) (
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] step_i,
  input  dir_e          last_i,
  input  dir_e          dir_i,
  output logic [PW-1:0] period_o,
  output logic [PW-1:0] step_o,
  output logic          clamp_lo_o,
  output logic          clamp_hi_o
);

  always_comb begin
    int   s;
    int   p;
    logic rev;
    rev = (last_i != DIR_NONE) && (dir_i != DIR_NONE) && (last_i != dir_i);
    s = next_step(int'(step_i), rev);
    p = moved(int'(period_i), s, dir_i);
    clamp_lo_o = (p < P_MIN);
    clamp_hi_o = (p > P_MAX);
    if (clamp_lo_o)      period_o = PW'(P_MIN);
    else if (clamp_hi_o) period_o = PW'(P_MAX);
    else                 period_o = PW'(p);
    step_o = PW'(s);
  end

endmodule

// File: rtl/mscal_iter.sv
module mscal_iter #(
  parameter int MAX_ITER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int IW = $clog2(MAX_ITER + 1);

  logic [IW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (clr_i) count_q <= '0;
    else if (inc_i) count_q <= count_q + 1'b1;
  end

  // the pass being evaluated is the final one allowed
  assign last_o = (count_q == IW'(MAX_ITER - 1));

  p_iter_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= IW'(MAX_ITER));

endmodule

// File: rtl/relax_period_cal.sv
module relax_period_cal
  import mscal_pkg::*;
#(
  parameter int N         = 10,
  parameter int PW        = 10,
  parameter int P_MIN     = 8,
  parameter int P_MAX     = 1000,
  parameter int P_INIT    = 256,
  parameter int STEP_INIT = 64,
  parameter int MAX_ITER  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_start,
  output logic [N-1:0]  seq_code,
  output logic          seq_start,
  input  logic          seq_done,
  input  logic          cmp_high,
  input  logic          cmp_low,
  input  logic          cmp_in_win,
  output logic [PW-1:0] period_cnt,
  output logic          cal_ok,
  output logic          cal_err
);

  localparam logic [N-1:0] CODE_MID   = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] CODE_BELOW = CODE_MID - 1'b1;

  cal_state_e    state_q;
  logic [PW-1:0] period_q;
  logic [PW-1:0] step_q;
  dir_e          last_q;
  cmp_t          cmp_q;
  logic          ok_q;
  logic          err_q;

  // named events
  logic          load_fire;
  logic          done_hi_fire;
  logic          sample_fire;
  logic          eval_fire;
  logic          adj_fire;
  logic          iter_last;
  dir_e          dir_w;
  logic [PW-1:0] adj_period;
  logic [PW-1:0] adj_step;
  logic          clamp_lo;
  logic          clamp_hi;
  logic          clamp_fire;

  assign load_fire    = (state_q == ST_IDLE) && cal_start;
  assign done_hi_fire = (state_q == ST_WAIT_HI) && seq_done;
  assign sample_fire  = (state_q == ST_WAIT_LO) && seq_done;
  assign eval_fire    = (state_q == ST_EVAL);
  assign dir_w        = decide(cmp_q);
  assign adj_fire     = eval_fire && !cmp_q.win && !iter_last && (dir_w != DIR_NONE);
  assign clamp_fire   = adj_fire && (clamp_lo || clamp_hi);

  mscal_adjust #(
    .PW   (PW),
    .P_MIN(P_MIN),
    .P_MAX(P_MAX)
  ) u_adjust (
    .period_i  (period_q),
    .step_i    (step_q),
    .last_i    (last_q),
    .dir_i     (dir_w),
    .period_o  (adj_period),
    .step_o    (adj_step),
    .clamp_lo_o(clamp_lo),
    .clamp_hi_o(clamp_hi)
  );

  mscal_iter #(
    .MAX_ITER(MAX_ITER)
  ) u_iter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (load_fire),
    .inc_i (eval_fire),
    .last_o(iter_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      period_q <= PW'(P_INIT);
      step_q   <= PW'(STEP_INIT);
      last_q   <= DIR_NONE;
      cmp_q    <= '0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cal_start) begin
            period_q <= PW'(P_INIT);
            step_q   <= PW'(STEP_INIT);
            last_q   <= DIR_NONE;
            ok_q     <= 1'b0;
            err_q    <= 1'b0;
            state_q  <= ST_REQ_HI;
          end
        end
        ST_REQ_HI:  state_q <= ST_WAIT_HI;
        ST_WAIT_HI: if (seq_done) state_q <= ST_REQ_LO;
        ST_REQ_LO:  state_q <= ST_WAIT_LO;
        ST_WAIT_LO: begin
          if (seq_done) begin
            cmp_q   <= '{hi: cmp_high, lo: cmp_low, win: cmp_in_win};
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (cmp_q.win) begin
            ok_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (iter_last) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (dir_w == DIR_NONE) begin
            state_q <= ST_REQ_HI;
          end else begin
            period_q <= adj_period;
            if (clamp_lo || clamp_hi) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              step_q  <= adj_step;
              last_q  <= dir_w;
              state_q <= ST_REQ_HI;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign seq_start  = (state_q == ST_REQ_HI) || (state_q == ST_REQ_LO);
  assign seq_code   = ((state_q == ST_REQ_LO) || (state_q == ST_WAIT_LO)) ? CODE_BELOW : CODE_MID;
  assign period_cnt = period_q;
  assign cal_ok     = ok_q;
  assign cal_err    = err_q;

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  p_second_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_hi_fire |=> (seq_start && seq_code == CODE_BELOW));

  p_verdict_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_fire |=> $stable(cmp_q));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_ok && cal_err));

  p_quiet_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cal_ok || cal_err) && !cal_start) |=> !seq_start);

  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_fire && !load_fire) |=> $stable(period_cnt));

  p_step_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != '0);

  p_restart_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_fire && !clamp_fire) |=> (seq_start && seq_code == CODE_MID));

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_cnt >= PW'(P_MIN)) && (period_cnt <= PW'(P_MAX)));

  p_clamp_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_fire |=> (cal_err && !seq_start));

endmodule

// File: tb/relax_period_cal_test.sv
module relax_period_cal_test;

  localparam int N         = 6;
  localparam int PW        = 6;
  localparam int P_MIN     = 4;
  localparam int P_MAX     = 40;
  localparam int P_INIT    = 20;
  localparam int STEP_INIT = 8;
  localparam int MAX_ITER  = 12;
  localparam int MIDC      = 1 << (N - 1);

  logic          clk;
  logic          rst_n;
  logic          cal_start;
  logic [N-1:0]  seq_code;
  logic          seq_start;
  logic          seq_done;
  logic          cmp_high;
  logic          cmp_low;
  logic          cmp_in_win;
  logic [PW-1:0] period_cnt;
  logic          cal_ok;
  logic          cal_err;

  int n_chk  = 0;
  int n_fail = 0;

  // comparator model state (target and tolerance in half-count units)
  int t2;
  int tol2;
  int obs_cnt;
  int conv_cnt;
  int order_err;
  bit expect_lo;
  int obs_period [64];

  relax_period_cal #(
    .N(N), .PW(PW), .P_MIN(P_MIN), .P_MAX(P_MAX),
    .P_INIT(P_INIT), .STEP_INIT(STEP_INIT), .MAX_ITER(MAX_ITER)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
    .seq_code(seq_code), .seq_start(seq_start), .seq_done(seq_done),
    .cmp_high(cmp_high), .cmp_low(cmp_low), .cmp_in_win(cmp_in_win),
    .period_cnt(period_cnt), .cal_ok(cal_ok), .cal_err(cal_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench restatement of the calibration loop, in signed direction units
  task automatic model(input int t, input int tol, output int fp, output int it,
                       output bit ok, output bit er, output int tr [64]);
    int p;
    int s;
    int last;
    int e;
    int d;
    int np;
    p = P_INIT; s = STEP_INIT; last = 0;
    ok = 0; er = 0; it = 0;
    for (int k = 0; k < 100; k++) begin
      tr[it] = p;
      it++;
      e = 2 * p - t;
      if (e <= tol && e >= -tol) begin ok = 1; break; end
      if (it == MAX_ITER) begin er = 1; break; end
      d = (e > 0) ? -1 : 1;
      if (last != 0 && last != d) s = (s > 1) ? s / 2 : 1;
      np = p + d * s;
      if (np < P_MIN) begin p = P_MIN; er = 1; break; end
      if (np > P_MAX) begin p = P_MAX; er = 1; break; end
      p = np;
      last = d;
    end
    fp = p;
  endtask

  // sequencer and comparator model
  initial begin
    int lat;
    int e;
    bit second;
    seq_done = 1'b0;
    {cmp_high, cmp_low, cmp_in_win} = 3'b000;
    forever begin
      @(negedge clk);
      while (seq_start) begin
        conv_cnt++;
        second = 1'b0;
        if (int'(seq_code) == MIDC) begin
          if (expect_lo) order_err++;
          if (obs_cnt < 64) obs_period[obs_cnt] = int'(period_cnt);
          obs_cnt++;
          expect_lo = 1'b1;
        end else if (int'(seq_code) == MIDC - 1) begin
          if (!expect_lo) order_err++;
          expect_lo = 1'b0;
          second = 1'b1;
        end else begin
          order_err++;
        end
        lat = 1 + int'($urandom % 4);
        for (int w = 0; w < lat; w++) begin
          {cmp_high, cmp_low, cmp_in_win} = 3'($urandom);
          @(negedge clk);
        end
        seq_done = 1'b1;
        if (second) begin
          e = 2 * int'(period_cnt) - t2;
          cmp_in_win = (e <= tol2 && e >= -tol2);
          cmp_high   = !cmp_in_win && (e > 0);
          cmp_low    = !cmp_in_win && (e < 0);
        end else begin
          {cmp_high, cmp_low, cmp_in_win} = 3'($urandom);
        end
        @(negedge clk);
        seq_done = 1'b0;
        {cmp_high, cmp_low, cmp_in_win} = 3'($urandom);
      end
    end
  end

  task automatic run_cal(input int t, input int tol, input bit poke);
    int ep;
    int ei;
    bit eok;
    bit eerr;
    int etr [64];
    int cyc;
    int hold;
    model(t, tol, ep, ei, eok, eerr, etr);
    t2 = t; tol2 = tol;
    obs_cnt = 0; conv_cnt = 0; order_err = 0; expect_lo = 1'b0;
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    check(!cal_ok && !cal_err && int'(period_cnt) == P_INIT, "R10 reload",
          int'(period_cnt), P_INIT);
    if (poke) begin
      repeat (3) @(negedge clk);
      cal_start = 1'b1;
      @(negedge clk) cal_start = 1'b0;
    end
    cyc = 0;
    while (!(cal_ok || cal_err) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc < 3000, "R3 run finished", cyc, 3000);
    check(int'(period_cnt) == ep, "R4/R7 final count", int'(period_cnt), ep);
    check(cal_ok == eok, "R3 ok flag", int'(cal_ok), int'(eok));
    check(cal_err == eerr, "R7/R8 err flag", int'(cal_err), int'(eerr));
    check(conv_cnt == 2 * ei, "R6 conversions", conv_cnt, 2 * ei);
    check(order_err == 0, "R1 code order", order_err, 0);
    for (int i = 0; i < ei && i < 64; i++)
      check(obs_period[i] == etr[i], "R5 per-pass count", obs_period[i], etr[i]);
    hold = int'(period_cnt);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!seq_start && int'(period_cnt) == hold, "R3 idle hold", int'(seq_start), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    cal_start = 1'b0;
    t2 = 0; tol2 = 0;
    obs_cnt = 0; conv_cnt = 0; order_err = 0; expect_lo = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(period_cnt) == P_INIT, "R9 reset count", int'(period_cnt), P_INIT);
    check(!cal_ok && !cal_err, "R9 reset flags", int'({cal_ok, cal_err}), 0);
    check(!seq_start, "R9 reset start", int'(seq_start), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 R3: immediate window, earlier comparator noise must not matter
    run_cal(40, 0, 1'b0);
    // R7: floor reached going down
    run_cal(6, 0, 1'b0);
    // R7: ceiling reached going up
    run_cal(90, 0, 1'b0);
    // R8: half-count target never lands in a zero window
    run_cal(55, 0, 1'b0);
    // R10: start pulse mid-run is ignored; R5 reversals toward the target
    run_cal(54, 1, 1'b1);
    run_cal(33, 0, 1'b0);
    for (int r = 0; r < 25; r++)
      run_cal(int'($urandom % 95), int'($urandom % 3), r[0]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule